// File: doc/BRIEF.md
# Three-Port Register File with Hardwired Zero Entry

This block is the architectural register store of a load-store processor core. It keeps 32 words of 32 bits. Two read ports deliver the two source operands of a three-operand instruction combinationally from their index inputs. One write port stores the destination result on the rising clock edge.

Entry 0 is not storage at all. It reads as the constant zero on both read ports, and writes aimed at it are silently dropped. Code can therefore use it as a zero source for moves, compares against zero and constant loads.

A synchronous active-high reset clears every entry. There is no write-through path. A read of the index being written in the same cycle sees the value held before that edge.

Top module: `rf3p_zero`

## Requirements
- R1: While `rst` is high at a rising clock edge, every entry is cleared, so afterwards both read ports return 0 for every index 0..31.
- R2: With `wr_en` high at a rising edge and `wr_addr` nonzero, the entry at `wr_addr` takes `wr_data`, and it is readable on either port right after that edge.
- R3: With `wr_en` low at a rising edge, no entry changes, whatever `wr_addr` and `wr_data` hold.
- R4: Index 0 returns 32'h0000_0000 on both `rd_a_data` and `rd_b_data` at all times.
- R5: A write with `wr_addr` equal to 0 changes no entry, and index 0 still reads as zero afterwards.
- R6: When a read port addresses the same nonzero index that is being written, it shows the old value until the edge and the new value after it.
- R7: The two read ports are independent: each returns the entry selected by its own 5-bit index, including when both select the same index.
- R8: A write to one index leaves every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all entries |
| wr_en | input | 1 | Write request for the destination port |
| wr_addr | input | 5 | Destination index |
| wr_data | input | 32 | Word to be stored |
| rd_a_addr | input | 5 | Index for the first source operand |
| rd_a_data | output | 32 | First source operand, combinational |
| rd_b_addr | input | 5 | Index for the second source operand |
| rd_b_data | output | 32 | Second source operand, combinational |

## Verification
Read results are due in the same cycle as the index change. The bench applies each new index away from the clock edge and samples one time step later. A write becomes visible only after the next rising edge, so write results are sampled one step after that edge, once the write enable has been released. For the collision case of R6, the read is sampled both before the edge, where the old value is expected, and after it, where the new value is expected. Expected values come from a reference array in the bench that is updated only for enabled writes to nonzero indices.

// File: rtl/rf3p_pkg.sv
package rf3p_pkg;
    parameter int RF_DEPTH_DEF = 32;
    parameter int RF_WIDTH_DEF = 32;
endpackage

// File: rtl/rf3p_wdec.sv
module rf3p_wdec #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    output logic [DEPTH-1:0] wr_sel
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        if (g == 0) begin : g_zero
            assign wr_sel[g] = 1'b0;
        end else begin : g_live
            assign wr_sel[g] = wr_en && (wr_addr == AW'(g));
        end
    end
endmodule

// File: rtl/rf3p_bank.sv
module rf3p_bank #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [DEPTH-1:0]            wr_sel,
    input  logic [WIDTH-1:0]            wr_data,
    output logic [DEPTH-1:0][WIDTH-1:0] cells
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        if (g == 0) begin : g_const
            assign cells[g] = '0;
        end else begin : g_reg
            logic [WIDTH-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_sel[g]) begin
                    q <= wr_data;
                end
            end
            assign cells[g] = q;
        end
    end
endmodule

// File: rtl/rf3p_rport.sv
module rf3p_rport #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][WIDTH-1:0] cells,
    input  logic [AW-1:0]               addr,
    output logic [WIDTH-1:0]            data
);
    always_comb begin
        data = cells[addr];
    end
endmodule

// File: rtl/rf3p_zero.sv
module rf3p_zero
    import rf3p_pkg::*;
#(
    parameter int DEPTH = RF_DEPTH_DEF,
    parameter int WIDTH = RF_WIDTH_DEF,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_a_addr,
    output logic [WIDTH-1:0] rd_a_data,
    input  logic [AW-1:0]    rd_b_addr,
    output logic [WIDTH-1:0] rd_b_data
);
    logic [DEPTH-1:0]            wr_sel;
    logic [DEPTH-1:0][WIDTH-1:0] cells;
    logic [WIDTH-1:0]            fold;

    rf3p_wdec #(.DEPTH(DEPTH)) u_wdec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_sel (wr_sel)
    );

    rf3p_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .cells  (cells)
    );

    rf3p_rport #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rport_a (
        .cells(cells),
        .addr (rd_a_addr),
        .data (rd_a_data)
    );

    rf3p_rport #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rport_b (
        .cells(cells),
        .addr (rd_b_addr),
        .data (rd_b_data)
    );

    // Rotating XOR signature of the whole store, used by the checks below.
    always_comb begin
        fold = '0;
        for (int i = 0; i < DEPTH; i++) begin
            fold = {fold[WIDTH-2:0], fold[WIDTH-1]} ^ cells[i];
        end
    end

    // R4: index 0 reads as zero on both ports.
    p_zero_port_a_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == '0) |-> (rd_a_data == '0));
    p_zero_port_b_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_b_addr == '0) |-> (rd_b_data == '0));

    // R2: an enabled write to a nonzero index lands in that entry.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0) |=> (cells[$past(wr_addr)] == $past(wr_data)));

    // R3: no enabled write means the store is unchanged.
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> $stable(fold));

    // R5: a write aimed at index 0 is dropped.
    p_zero_write_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0) |=> $stable(fold));
endmodule

// File: tb/test_rf3p_zero.sv
module test_rf3p_zero;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_a_addr = '0;
    logic [31:0] rd_a_data;
    logic [4:0]  rd_b_addr = '0;
    logic [31:0] rd_b_data;

    logic [31:0] model [32];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rf3p_zero i_rf3p_zero (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
    );

    function automatic logic [31:0] pat(input int i, input int salt);
        return (32'(i) * 32'h9E37_79B9) ^ (32'(salt) * 32'h0101_0101) ^ 32'h5A00_00A5;
    endfunction

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd2(input string req, input int a, input int b);
        rd_a_addr = 5'(a);
        rd_b_addr = 5'(b);
        #1;
        cmp(req, rd_a_data, model[a]);
        cmp(req, rd_b_data, model[b]);
    endtask

    task automatic wr(input int a, input logic [31:0] d, input logic en);
        @(negedge clk);
        wr_en = en; wr_addr = 5'(a); wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (en && a != 0) model[a] = d;
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 32; i++) rd2(req, i, 31 - i);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        sweep("R1");

        // R2 / R5: write every index, including 0.
        for (int i = 0; i < 32; i++) wr(i, pat(i, 1), 1'b1);
        sweep("R2");
        rd2("R5", 0, 0);
        cmp("R4", rd_a_data, 32'h0);

        // R7: both ports on same index, then different ones.
        for (int i = 0; i < 32; i++) rd2("R7", i, i);
        for (int i = 0; i < 32; i++) rd2("R7", i, (i + 7) % 32);

        // R3: disabled writes with live data.
        for (int i = 0; i < 32; i++) wr(i, ~pat(i, 2), 1'b0);
        sweep("R3");

        // R8: one write, all others untouched.
        wr(13, 32'hDEAD_BEEF, 1'b1);
        sweep("R8");

        // R5: repeated writes to index 0.
        for (int k = 0; k < 20; k++) wr(0, $urandom | 32'h1, 1'b1);
        sweep("R5");

        // R6: same-cycle read and write collisions.
        for (int i = 1; i < 32; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 5'(i); wr_data = pat(i, 3);
            rd_a_addr = 5'(i); rd_b_addr = 5'(i);
            #1;
            cmp("R6", rd_a_data, model[i]);
            cmp("R6", rd_b_data, model[i]);
            @(posedge clk);
            #1;
            wr_en = 1'b0;
            model[i] = pat(i, 3);
            cmp("R6", rd_a_data, model[i]);
            cmp("R6", rd_b_data, model[i]);
        end

        // Random mix checked against the model.
        for (int k = 0; k < 400; k++) begin
            wr(int'($urandom % 32), $urandom, 1'($urandom));
            rd2("R2", int'($urandom % 32), int'($urandom % 32));
        end

        // R1: reset clears a populated store.
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = '0;
        sweep("R1");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule